// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular buffer that gives every dispatched instruction a slot and hands back the slot index as that instruction's rename tag. Execution units finish in any order and write their results back by tag. The buffer retires slots only from the oldest end, one per cycle, and turns each retirement into a register-file write, a memory-write strobe or no write at all. Until a result retires, two operand-lookup ports let dispatch find the youngest in-flight producer of a register. A port returns that producer's tag, and also its value once the value is known.

A slot holds the instruction class, the destination register, the result value, a ready bit and two fault marks (exception and mispredict). A marked slot cannot retire. When it reaches the oldest position with its result present, the buffer raises a trap pulse and discards every entry. The same discard happens when the flush input is driven. The depth must be a power of two.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `dispReady` is 1, `dispTag` is 0, and `cmtValid`, `cmtRegWe`, `cmtMemWe`, `flushOut` and every `lkHit` bit are 0.
- R2: An accepted dispatch (`dispValid` and `dispReady` both high) takes the slot shown on `dispTag` in that cycle. The next slot, modulo DEPTH, appears on `dispTag` in the following cycle. `dispKind` is encoded as 0 = register write, 1 = store, 2 = branch.
- R3: Once DEPTH slots are in flight, `dispReady` is 0. A `dispValid` in that state is ignored: `dispTag` holds and the entries remain unchanged.
- R4: A writeback (`wbValid`, `wbTag`, `wbValue`) marks the in-flight slot as ready and stores the value. A writeback to a tag that is not in flight is ignored.
- R5: Only the oldest slot can retire, and only when it is ready and carries no fault mark. In that cycle `cmtValid` is 1 and `cmtTag` equals its tag. Ready slots that are younger wait. Consecutive retirements carry consecutive tags.
- R6: A retiring register-write slot raises `cmtRegWe` and drives its destination on `cmtDest` and its value on `cmtValue`. A retiring store raises `cmtMemWe` instead. A retiring branch raises neither.
- R7: Lookup port p reports the youngest in-flight register-write slot whose destination equals `lkReg[p]`. It drives `lkHit`, `lkTag`, `lkReady` and `lkValue`, and `lkValue` is 0 while the slot is not ready. Store and branch slots never match.
- R8: After a slot retires, lookups stop matching it.
- R9: When the oldest slot is ready and marked (`wbExc` or `wbMisp` was set at writeback), `flushOut` is 1 for that cycle. Nothing retires and `dispReady` is 0. In the next cycle the buffer is empty and tags restart at 0.
- R10: `flushIn` empties the buffer at the next edge. A dispatch in the same cycle is refused (`dispReady` is 0), and `flushOut` stays 0.
- R11: In any cycle at most one of `cmtRegWe`, `cmtMemWe` and `flushOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispKind | input | 2 | Instruction class (0 reg, 1 store, 2 branch) |
| dispDest | input | REG_W | Destination register |
| dispReady | output | 1 | Slot available this cycle |
| dispTag | output | TAG_W | Tag given to this cycle's dispatch |
| wbValid | input | 1 | Writeback strobe |
| wbTag | input | TAG_W | Slot being written back |
| wbValue | input | DATA_W | Result value |
| wbExc | input | 1 | Result raised an exception |
| wbMisp | input | 1 | Branch was mispredicted |
| lkReg | input | 2 x REG_W | Source registers to look up |
| lkHit | output | 2 | In-flight producer found |
| lkTag | output | 2 x TAG_W | Tag of the youngest producer |
| lkReady | output | 2 | Producer value present |
| lkValue | output | 2 x DATA_W | Producer value (0 when not ready) |
| cmtValid | output | 1 | Oldest slot retires this cycle |
| cmtTag | output | TAG_W | Tag of the retiring slot |
| cmtRegWe | output | 1 | Register-file write strobe |
| cmtMemWe | output | 1 | Memory-write strobe |
| cmtDest | output | REG_W | Destination of the retiring slot |
| cmtValue | output | DATA_W | Value of the retiring slot |
| flushIn | input | 1 | External discard request |
| flushOut | output | 1 | Trap: marked oldest slot is emptying the buffer |

## Verification
The bound checker watches every cycle for the rules that can be stated locally in time: the write strobes and the trap never overlap, tags advance by one on each accepted dispatch and hold while dispatch is stalled, retirements in back-to-back cycles carry consecutive tags, and after any flush the buffer shows nothing retiring and no lookup hits. Other behaviour can only be shown by the bench's scenarios, because each depends on stored history across many cycles: a younger ready result waits behind an older one, lookups return the youngest producer across a wrap of the pointers, a stray writeback leaves no trace, and each retirement carries the correct destination and value.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int LK_PORTS = 2;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic allocEn;
    logic commitEn;
    logic flushEn;
  } rob_strobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             flushIn,
  input  logic             headReady,
  input  logic             headFlag,
  output rob_strobe_t      strobe,
  output logic             trapEn,
  output logic [TAG_W-1:0] headPtr,
  output logic [TAG_W-1:0] tailPtr,
  output logic             full
);
  logic [CNT_W-1:0] count;
  logic             empty;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // a marked oldest entry with its result present traps instead of retiring
  assign trapEn          = !empty && headReady && headFlag;
  assign strobe.flushEn  = flushIn || trapEn;
  assign strobe.commitEn = !empty && headReady && !headFlag && !flushIn;
  assign strobe.allocEn  = dispValid && !full && !strobe.flushEn;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushEn) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.commitEn) headPtr <= headPtr + TAG_W'(1);
      if (strobe.allocEn)  tailPtr <= tailPtr + TAG_W'(1);
      count <= count + CNT_W'(strobe.allocEn) - CNT_W'(strobe.commitEn);
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  rob_strobe_t                          strobe,
  input  logic [TAG_W-1:0]                     headPtr,
  input  logic [TAG_W-1:0]                     tailPtr,
  input  logic [1:0]                           dispKind,
  input  logic [REG_W-1:0]                     dispDest,
  input  logic                                 wbValid,
  input  logic [TAG_W-1:0]                     wbTag,
  input  logic [DATA_W-1:0]                    wbValue,
  input  logic                                 wbExc,
  input  logic                                 wbMisp,
  input  logic [LK_PORTS-1:0][REG_W-1:0]       lkReg,
  output logic [LK_PORTS-1:0]                  lkHit,
  output logic [LK_PORTS-1:0][TAG_W-1:0]       lkTag,
  output logic [LK_PORTS-1:0]                  lkReady,
  output logic [LK_PORTS-1:0][DATA_W-1:0]      lkValue,
  output logic                                 headReady,
  output logic                                 headFlag,
  output logic                                 cmtRegWe,
  output logic                                 cmtMemWe,
  output logic [REG_W-1:0]                     cmtDest,
  output logic [DATA_W-1:0]                    cmtValue
);
  logic [DEPTH-1:0]  busy;
  logic [DEPTH-1:0]  ready;
  logic [DEPTH-1:0]  excMark;
  logic [DEPTH-1:0]  mispMark;
  kind_t             kind  [DEPTH];
  logic [REG_W-1:0]  dest  [DEPTH];
  logic [DATA_W-1:0] value [DEPTH];

  assign headReady = busy[headPtr] && ready[headPtr];
  assign headFlag  = excMark[headPtr] || mispMark[headPtr];
  assign cmtRegWe  = strobe.commitEn && (kind[headPtr] == KIND_REG);
  assign cmtMemWe  = strobe.commitEn && (kind[headPtr] == KIND_STORE);
  assign cmtDest   = dest[headPtr];
  assign cmtValue  = value[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushEn) begin
      busy  <= '0;
      ready <= '0;
    end else begin
      if (strobe.commitEn) begin
        busy[headPtr]  <= 1'b0;
        ready[headPtr] <= 1'b0;
      end
      if (wbValid && busy[wbTag]) begin
        ready[wbTag]    <= 1'b1;
        value[wbTag]    <= wbValue;
        excMark[wbTag]  <= wbExc;
        mispMark[wbTag] <= wbMisp;
      end
      if (strobe.allocEn) begin
        busy[tailPtr]     <= 1'b1;
        ready[tailPtr]    <= 1'b0;
        kind[tailPtr]     <= kind_t'(dispKind);
        dest[tailPtr]     <= dispDest;
        excMark[tailPtr]  <= 1'b0;
        mispMark[tailPtr] <= 1'b0;
      end
    end
  end

  // oldest-to-youngest scan; a later match overrides, leaving the youngest
  for (genvar p = 0; p < LK_PORTS; p++) begin : g_lookup
    logic              hitL;
    logic              readyL;
    logic [TAG_W-1:0]  tagL;
    logic [TAG_W-1:0]  idx;
    logic [DATA_W-1:0] valL;

    always_comb begin
      hitL   = 1'b0;
      readyL = 1'b0;
      tagL   = '0;
      valL   = '0;
      idx    = '0;
      for (int off = 0; off < DEPTH; off++) begin
        idx = headPtr + TAG_W'(off);
        if (busy[idx] && kind[idx] == KIND_REG && dest[idx] == lkReg[p]) begin
          hitL   = 1'b1;
          tagL   = idx;
          readyL = ready[idx];
          valL   = ready[idx] ? value[idx] : '0;
        end
      end
    end

    assign lkHit[p]   = hitL;
    assign lkTag[p]   = tagL;
    assign lkReady[p] = readyL;
    assign lkValue[p] = valL;
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            dispValid,
  input  logic [1:0]                      dispKind,
  input  logic [REG_W-1:0]                dispDest,
  output logic                            dispReady,
  output logic [TAG_W-1:0]                dispTag,
  input  logic                            wbValid,
  input  logic [TAG_W-1:0]                wbTag,
  input  logic [DATA_W-1:0]               wbValue,
  input  logic                            wbExc,
  input  logic                            wbMisp,
  input  logic [LK_PORTS-1:0][REG_W-1:0]  lkReg,
  output logic [LK_PORTS-1:0]             lkHit,
  output logic [LK_PORTS-1:0][TAG_W-1:0]  lkTag,
  output logic [LK_PORTS-1:0]             lkReady,
  output logic [LK_PORTS-1:0][DATA_W-1:0] lkValue,
  output logic                            cmtValid,
  output logic [TAG_W-1:0]                cmtTag,
  output logic                            cmtRegWe,
  output logic                            cmtMemWe,
  output logic [REG_W-1:0]                cmtDest,
  output logic [DATA_W-1:0]               cmtValue,
  input  logic                            flushIn,
  output logic                            flushOut
);
  rob_strobe_t      strobe;
  logic             trapEn;
  logic [TAG_W-1:0] headPtr;
  logic [TAG_W-1:0] tailPtr;
  logic             full;
  logic             headReady;
  logic             headFlag;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .flushIn(flushIn),
    .headReady(headReady), .headFlag(headFlag), .strobe(strobe),
    .trapEn(trapEn), .headPtr(headPtr), .tailPtr(tailPtr), .full(full)
  );

  rob_data #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headPtr(headPtr), .tailPtr(tailPtr),
    .dispKind(dispKind), .dispDest(dispDest),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue), .wbExc(wbExc), .wbMisp(wbMisp),
    .lkReg(lkReg), .lkHit(lkHit), .lkTag(lkTag), .lkReady(lkReady), .lkValue(lkValue),
    .headReady(headReady), .headFlag(headFlag),
    .cmtRegWe(cmtRegWe), .cmtMemWe(cmtMemWe), .cmtDest(cmtDest), .cmtValue(cmtValue)
  );

  assign dispReady = !full && !strobe.flushEn;
  assign dispTag   = tailPtr;
  assign cmtValid  = strobe.commitEn;
  assign cmtTag    = headPtr;
  assign flushOut  = trapEn;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rstN,
  input logic                dispValid,
  input logic                dispReady,
  input logic [TAG_W-1:0]    dispTag,
  input logic                flushIn,
  input logic                flushOut,
  input logic                cmtValid,
  input logic [TAG_W-1:0]    cmtTag,
  input logic                cmtRegWe,
  input logic                cmtMemWe,
  input logic [LK_PORTS-1:0] lkHit
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmtRegWe, cmtMemWe, flushOut})); // R11

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> dispTag == $past(dispTag) + TAG_W'(1)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !dispReady && !flushIn && !flushOut |=> dispTag == $past(dispTag)); // R3

  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && $past(cmtValid) |-> cmtTag == $past(cmtTag) + TAG_W'(1)); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flushIn || flushOut |=> !cmtValid && !flushOut && lkHit == '0 && dispTag == '0); // R9

  AST_TRAP_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> !cmtValid && !dispReady); // R9
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rob_core_bench.sv
module rob_core_bench;
  localparam int DEPTH = 8;
  localparam int REG_W = 5;
  localparam int DATA_W = 32;
  localparam int TAG_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic [1:0] dispKind = '0;
  logic [REG_W-1:0] dispDest = '0;
  logic dispReady;
  logic [TAG_W-1:0] dispTag;
  logic wbValid = 1'b0;
  logic [TAG_W-1:0] wbTag = '0;
  logic [DATA_W-1:0] wbValue = '0;
  logic wbExc = 1'b0;
  logic wbMisp = 1'b0;
  logic [1:0][REG_W-1:0] lkReg = '0;
  logic [1:0] lkHit;
  logic [1:0][TAG_W-1:0] lkTag;
  logic [1:0] lkReady;
  logic [1:0][DATA_W-1:0] lkValue;
  logic cmtValid;
  logic [TAG_W-1:0] cmtTag;
  logic cmtRegWe;
  logic cmtMemWe;
  logic [REG_W-1:0] cmtDest;
  logic [DATA_W-1:0] cmtValue;
  logic flushIn = 1'b0;
  logic flushOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_rob_core (.*);

  // dispatch vectors: {kind, dest}; expected tag is the row index
  localparam logic [6:0] DISP_TBL [6] = '{
    {2'd0, 5'd3}, {2'd0, 5'd5}, {2'd1, 5'd3},
    {2'd0, 5'd3}, {2'd2, 5'd0}, {2'd0, 5'd7}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic writeBack(input int tag, input logic [31:0] val, input bit exc, input bit misp);
    wbValid = 1'b1; wbTag = TAG_W'(tag); wbValue = val; wbExc = exc; wbMisp = misp;
    step();
    wbValid = 1'b0; wbExc = 1'b0; wbMisp = 1'b0;
  endtask

  task automatic dispatch(input logic [1:0] k, input logic [4:0] d);
    dispValid = 1'b1; dispKind = k; dispDest = d;
    step();
    dispValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    settle();
    // R1 reset state
    check(dispReady && dispTag == 0, "R1 ready/tag", {dispReady, dispTag}, {1'b1, 3'd0});
    check(!cmtValid && !cmtRegWe && !cmtMemWe && !flushOut && lkHit == 0, "R1 idle outputs",
          {cmtValid, cmtRegWe, cmtMemWe, flushOut, lkHit}, 0);

    // R2 table walk: tags follow allocation order
    for (int i = 0; i < 6; i++) begin
      dispValid = 1'b1; dispKind = DISP_TBL[i][6:5]; dispDest = DISP_TBL[i][4:0];
      settle();
      check(dispReady && dispTag == TAG_W'(i), "R2 dispatch tag", dispTag, i);
      step();
    end
    dispValid = 1'b0;

    // R7 youngest reg-writer of r3 is tag 3 (store tag 2 ignored); r4 misses
    lkReg[0] = 5'd3; lkReg[1] = 5'd4;
    settle();
    check(lkHit[0] && lkTag[0] == 3 && !lkReady[0] && lkValue[0] == 0, "R7 youngest pending",
          {lkHit[0], lkTag[0], lkReady[0]}, {1'b1, 3'd3, 1'b0});
    check(!lkHit[1], "R7 no producer", lkHit[1], 0);

    // R4 writeback, R5 younger ready waits
    writeBack(3, 32'h33, 0, 0);
    check(lkHit[0] && lkReady[0] && lkValue[0] == 32'h33, "R4 ready value", lkValue[0], 32'h33);
    check(!cmtValid, "R5 younger waits", cmtValid, 0);

    writeBack(1, 32'h11, 0, 0);
    check(!cmtValid, "R5 head not ready", cmtValid, 0);
    writeBack(0, 32'h10, 0, 0);
    check(cmtValid && cmtTag == 0 && cmtRegWe && !cmtMemWe && cmtDest == 3 && cmtValue == 32'h10,
          "R6 reg retire tag0", {cmtValid, cmtTag, cmtDest, cmtValue}, {1'b1, 3'd0, 5'd3, 32'h10});
    step();
    check(cmtValid && cmtTag == 1 && cmtRegWe && cmtDest == 5 && cmtValue == 32'h11,
          "R5 retire tag1", {cmtTag, cmtValue}, {3'd1, 32'h11});
    step();
    lkReg[1] = 5'd5;
    settle();
    check(!cmtValid, "R5 stall on tag2", cmtValid, 0);
    check(!lkHit[1], "R8 retired no hit", lkHit[1], 0);

    writeBack(2, 32'h22, 0, 0);
    check(cmtValid && cmtTag == 2 && cmtMemWe && !cmtRegWe && cmtValue == 32'h22,
          "R6 store retire", {cmtMemWe, cmtRegWe, cmtValue}, {1'b1, 1'b0, 32'h22});
    step();
    check(cmtValid && cmtTag == 3 && cmtRegWe && cmtDest == 3 && cmtValue == 32'h33,
          "R5 retire tag3", {cmtTag, cmtValue}, {3'd3, 32'h33});
    step();
    check(!cmtValid && !lkHit[0], "R8 r3 gone after retire", {cmtValid, lkHit[0]}, 0);

    writeBack(4, 32'h0, 0, 0);
    check(cmtValid && cmtTag == 4 && !cmtRegWe && !cmtMemWe, "R6 branch no strobe",
          {cmtValid, cmtRegWe, cmtMemWe}, {1'b1, 2'b00});
    step();

    // R4 stray writeback to tag 7 (not in flight)
    writeBack(7, 32'hff, 0, 0);
    lkReg[0] = 5'd7;
    settle();
    check(!cmtValid && lkHit[0] && lkTag[0] == 5 && !lkReady[0], "R4 stray ignored",
          {cmtValid, lkTag[0], lkReady[0]}, {1'b0, 3'd5, 1'b0});

    // R3 fill with wrap, then stall
    for (int j = 0; j < 7; j++) begin
      dispValid = 1'b1; dispKind = 2'd0; dispDest = 5'd9;
      settle();
      check(dispReady && dispTag == TAG_W'(6 + j), "R2 wrap tag", dispTag, (6 + j) % 8);
      step();
    end
    settle();
    check(!dispReady, "R3 full stall", dispReady, 0);
    step();
    check(!dispReady && dispTag == 5, "R3 stalled dispatch ignored", {dispReady, dispTag}, {1'b0, 3'd5});
    dispValid = 1'b0;
    lkReg[0] = 5'd9;
    settle();
    check(lkHit[0] && lkTag[0] == 4, "R7 youngest across wrap", lkTag[0], 4);

    // R9 exception at head
    writeBack(5, 32'h55, 1, 0);
    check(flushOut && !cmtValid && !cmtRegWe && !dispReady, "R9 trap pulse",
          {flushOut, cmtValid, cmtRegWe, dispReady}, 4'b1000);
    check(!(cmtRegWe && flushOut) && !(cmtMemWe && flushOut), "R11 exclusive", {cmtRegWe, cmtMemWe, flushOut}, 3'b001);
    step();
    check(!flushOut && dispReady && dispTag == 0 && !lkHit[0], "R9 emptied",
          {flushOut, dispReady, dispTag, lkHit[0]}, {1'b0, 1'b1, 3'd0, 1'b0});

    // R10 external flush
    dispatch(2'd0, 5'd2);
    dispatch(2'd0, 5'd2);
    lkReg[0] = 5'd2;
    settle();
    check(lkHit[0] && lkTag[0] == 1, "R10 setup", lkTag[0], 1);
    flushIn = 1'b1; dispValid = 1'b1;
    settle();
    check(!dispReady && !flushOut, "R10 dispatch refused", {dispReady, flushOut}, 0);
    step();
    flushIn = 1'b0; dispValid = 1'b0;
    settle();
    check(dispTag == 0 && !lkHit[0], "R10 emptied", {dispTag, lkHit[0]}, 0);

    // R9 mispredict at head
    dispatch(2'd2, 5'd0);
    writeBack(0, 32'h0, 0, 1);
    check(flushOut && !cmtValid, "R9 mispredict trap", {flushOut, cmtValid}, 2'b10);
    step();
    check(dispTag == 0 && !flushOut, "R9 tags restart", {dispTag, flushOut}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule